// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit gathers single-cycle event pulses from the receive path, the transmit path and the descriptor engine of a network controller. Each event sets its own sticky bit in a 16-bit status register. A 16-bit mask register selects which pending bits may raise the interrupt line. A control register holds four settings: a global interrupt enable, a software-forced interrupt, a choice between two clear policies, and the enable for reporting bus failures.

Pending bits are cleared in one of two ways, chosen at run time:

- Write-one-to-clear: a status write clears each bit written as one.
- Clear-on-read: a status read returns the pending set and then empties it.

One status bit is not an event. It is a level that reports whether the free transmit memory count has reached the space threshold. It follows that comparison on every cycle, and neither clear policy affects it. The interrupt line is a registered OR of the masked status, gated by the global enable.

Software reaches the unit through a simple register port. Writes take effect on the clock edge. Reads are combinational from the stored state. Register selector values: 0 is status, 1 is mask, 2 is control.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status, mask and control registers read 0 and `irq_o` is 0.
- R2: A one-cycle pulse latches a status bit that stays set until cleared. The pulses map to bits as follows: `rx_early_i` 13, `rx_dzero_i` 12, `rx_fill_i` 11, `rx_pkt_i` 10, `rx_err_i` 9, `tx_dzero_i` 5, `tx_done_i` 3, `tx_err_i` 1. Bits 0, 6, 7, 8, 14 and 15 always read 0.
- R3: The policy is write-one-to-clear when control bit 2 is 0. A status write clears exactly the bits written as 1. Status reads clear nothing.
- R4: The policy is clear-on-read when control bit 2 is 1. A status read returns the pending bits, and every latched bit is 0 from the next cycle on. Status writes have no effect.
- R5: An event arriving in the same cycle as a clear of its bit (by write or by read) leaves the bit set.
- R6: Status bit 4 is 1 exactly when `tx_free_i` was at least SPACE_MIN (8192) in the previous cycle. Writes and reads never clear it.
- R7: Status bit 2 latches on `link_down_i`. It latches on `bus_fail_i` only while control bit 3 is 1.
- R8: `irq_o` is 1 in the cycle after control bit 0 (enable) is 1 and either some status bit is 1 with its mask bit 1, or control bit 1 (force) is 1.
- R9: `irq_o` is 0 in the cycle after the enable bit is 0, whatever the status, mask and force bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_early_i | input | 1 | Early-receive event pulse |
| rx_dzero_i | input | 1 | Receive descriptor count reached zero |
| rx_fill_i | input | 1 | Receive descriptor fill finished |
| rx_pkt_i | input | 1 | Packet received |
| rx_err_i | input | 1 | Receive error |
| tx_dzero_i | input | 1 | Transmit descriptor count reached zero |
| tx_done_i | input | 1 | Transmission finished |
| tx_err_i | input | 1 | Transmit error |
| link_down_i | input | 1 | Link lost |
| bus_fail_i | input | 1 | Host bus failure |
| tx_free_i | input | FREE_W | Free transmit memory in bytes |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register selector: 0 status, 1 mask, 2 control |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things:

- an event pulse always leaves its bit set, even against a clear;
- a write-one-to-clear or a clear-on-read empties the targeted bit when no event competes;
- the space bit tracks the threshold comparison of the previous cycle;
- the interrupt line follows the enable and the masked status.

Some behaviour can only be shown by the bench's scenarios:

- reads that must not clear in write-one-to-clear mode;
- writes that must be ignored in clear-on-read mode;
- the bus-fail gating of the miscellaneous error bit;
- the exact threshold boundary at 8191, 8192 and 8193 free bytes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned ADR_W = 2;

  localparam logic [ADR_W-1:0] ADR_STS = 2'd0;
  localparam logic [ADR_W-1:0] ADR_MSK = 2'd1;
  localparam logic [ADR_W-1:0] ADR_CTL = 2'd2;

  // status bit positions
  localparam int unsigned B_RX_EARLY = 13;
  localparam int unsigned B_RX_DZERO = 12;
  localparam int unsigned B_RX_FILL  = 11;
  localparam int unsigned B_RX_PKT   = 10;
  localparam int unsigned B_RX_ERR   = 9;
  localparam int unsigned B_TX_DZERO = 5;
  localparam int unsigned B_TX_SPACE = 4;
  localparam int unsigned B_TX_DONE  = 3;
  localparam int unsigned B_MISC     = 2;
  localparam int unsigned B_TX_ERR   = 1;

  localparam logic [REG_W-1:0] STS_VALID = 16'h3E3E;

  // control bits
  localparam int unsigned CTL_W     = 4;
  localparam int unsigned C_EN      = 0;
  localparam int unsigned C_FORCE   = 1;
  localparam int unsigned C_COR     = 2;
  localparam int unsigned C_BUSFAIL = 3;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_s,
  input  logic             msk_we,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] msk_q,
  output logic [CTL_W-1:0] ctl_q
);
  logic [REG_W-1:0] msk_d;
  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    msk_d = msk_we ? wdata : msk_q;
    ctl_d = ctl_we ? wdata[CTL_W-1:0] : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      msk_q <= '0;
      ctl_q <= '0;
    end else begin
      msk_q <= msk_d;
      ctl_q <= ctl_d;
    end
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned           W     = 16,
  parameter logic [W-1:0]          VALID = '1
) (
  input  logic         clk,
  input  logic         rst_s,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] sts_q
);
  logic [W-1:0] sts_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      // set has priority over clear
      always_comb sts_d[i] = set_v[i] | (sts_q[i] & ~clr_v[i]);
    end else begin : g_tied
      always_comb sts_d[i] = 1'b0 & (set_v[i] | clr_v[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) sts_q <= '0;
    else        sts_q <= sts_d;
  end
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_s,
  input  logic [REG_W-1:0] sts,
  input  logic [REG_W-1:0] msk,
  input  logic             en,
  input  logic             force_int,
  output logic             irq_q
);
  logic irq_d;

  always_comb begin
    irq_d = en & ((|(sts & msk)) | force_int);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int unsigned FREE_W    = 16,
  parameter int unsigned SPACE_MIN = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_early_i,
  input  logic              rx_dzero_i,
  input  logic              rx_fill_i,
  input  logic              rx_pkt_i,
  input  logic              rx_err_i,
  input  logic              tx_dzero_i,
  input  logic              tx_done_i,
  input  logic              tx_err_i,
  input  logic              link_down_i,
  input  logic              bus_fail_i,
  input  logic [FREE_W-1:0] tx_free_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADR_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  localparam logic [FREE_W:0] SPACE_LIM = (FREE_W+1)'(SPACE_MIN);

  logic             rst_s;
  logic [REG_W-1:0] sts_q;
  logic [REG_W-1:0] msk_q;
  logic [CTL_W-1:0] ctl_q;
  logic [REG_W-1:0] set_v;
  logic [REG_W-1:0] clr_v;
  logic             space_ok;
  logic             misc_ev;
  logic             w1c;
  logic             cor;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  // register decode
  always_comb begin
    w1c = reg_wr_i & (reg_addr_i == ADR_STS) & ~ctl_q[C_COR];
    cor = reg_rd_i & (reg_addr_i == ADR_STS) &  ctl_q[C_COR];
  end

  // event and level sources
  always_comb begin
    space_ok = {1'b0, tx_free_i} >= SPACE_LIM;
    misc_ev  = link_down_i | (bus_fail_i & ctl_q[C_BUSFAIL]);
    set_v             = '0;
    set_v[B_RX_EARLY] = rx_early_i;
    set_v[B_RX_DZERO] = rx_dzero_i;
    set_v[B_RX_FILL]  = rx_fill_i;
    set_v[B_RX_PKT]   = rx_pkt_i;
    set_v[B_RX_ERR]   = rx_err_i;
    set_v[B_TX_DZERO] = tx_dzero_i;
    set_v[B_TX_SPACE] = space_ok;
    set_v[B_TX_DONE]  = tx_done_i;
    set_v[B_MISC]     = misc_ev;
    set_v[B_TX_ERR]   = tx_err_i;
  end

  // clear sources; the level bit is cleared only by its own comparison
  always_comb begin
    clr_v             = ({REG_W{w1c}} & reg_wdata_i) | {REG_W{cor}};
    clr_v[B_TX_SPACE] = ~space_ok;
  end

  irq_status_bank #(.W(REG_W), .VALID(STS_VALID)) u_sts (
    .clk   (clk),
    .rst_s (rst_s),
    .set_v (set_v),
    .clr_v (clr_v),
    .sts_q (sts_q)
  );

  irq_cfg_regs u_cfg (
    .clk    (clk),
    .rst_s  (rst_s),
    .msk_we (reg_wr_i & (reg_addr_i == ADR_MSK)),
    .ctl_we (reg_wr_i & (reg_addr_i == ADR_CTL)),
    .wdata  (reg_wdata_i),
    .msk_q  (msk_q),
    .ctl_q  (ctl_q)
  );

  irq_out_reg u_irq (
    .clk       (clk),
    .rst_s     (rst_s),
    .sts       (sts_q),
    .msk       (msk_q),
    .en        (ctl_q[C_EN]),
    .force_int (ctl_q[C_FORCE]),
    .irq_q     (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADR_STS: reg_rdata_o = sts_q;
      ADR_MSK: reg_rdata_o = msk_q;
      ADR_CTL: reg_rdata_o = {{(REG_W-CTL_W){1'b0}}, ctl_q};
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import irq_pkg::*;
#(
  parameter int unsigned FREE_W    = 16,
  parameter int unsigned SPACE_MIN = 8192
) (
  input logic              clk,
  input logic              rst_s,
  input logic              rx_pkt_i,
  input logic              rx_err_i,
  input logic              tx_done_i,
  input logic [FREE_W-1:0] tx_free_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADR_W-1:0]  reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [REG_W-1:0]  sts_q,
  input logic [REG_W-1:0]  msk_q,
  input logic [CTL_W-1:0]  ctl_q,
  input logic              irq_o
);
  localparam logic [FREE_W:0] LIM = (FREE_W+1)'(SPACE_MIN);

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (sts_q & ~STS_VALID) == '0);

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_s)
    rx_pkt_i |=> sts_q[B_RX_PKT]);

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_wr_i && reg_addr_i == ADR_STS && !ctl_q[C_COR] && reg_wdata_i[B_TX_DONE]
     && !tx_done_i) |=> !sts_q[B_TX_DONE]);

  assert_cor_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_rd_i && reg_addr_i == ADR_STS && ctl_q[C_COR] && !rx_err_i)
    |=> !sts_q[B_RX_ERR]);

  assert_space_hi_R6: assert property (@(posedge clk) disable iff (!rst_s)
    ({1'b0, tx_free_i} >= LIM) |=> sts_q[B_TX_SPACE]);

  assert_space_lo_R6: assert property (@(posedge clk) disable iff (!rst_s)
    ({1'b0, tx_free_i} < LIM) |=> !sts_q[B_TX_SPACE]);

  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (ctl_q[C_EN] && ((sts_q & msk_q) != '0)) |=> irq_o);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !ctl_q[C_EN] |=> !irq_o);
endmodule

bind irq_status_unit irq_status_unit_chk #(.FREE_W(FREE_W), .SPACE_MIN(SPACE_MIN)) u_chk (
  .clk         (clk),
  .rst_s       (rst_s),
  .rx_pkt_i    (rx_pkt_i),
  .rx_err_i    (rx_err_i),
  .tx_done_i   (tx_done_i),
  .tx_free_i   (tx_free_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .sts_q       (sts_q),
  .msk_q       (msk_q),
  .ctl_q       (ctl_q),
  .irq_o       (irq_o)
);

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam int FREE_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_early_i = 0, rx_dzero_i = 0, rx_fill_i = 0, rx_pkt_i = 0, rx_err_i = 0;
  logic tx_dzero_i = 0, tx_done_i = 0, tx_err_i = 0, link_down_i = 0, bus_fail_i = 0;
  logic [FREE_W-1:0] tx_free_i = '0;
  logic reg_wr_i = 0, reg_rd_i = 0;
  logic [1:0] reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic irq_o;

  int total = 0;
  int bad = 0;
  logic [15:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 0; reg_wdata_i = '0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd_i = 1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk);
    reg_rd_i = 0;
  endtask

  // order: rx_early rx_dzero rx_fill rx_pkt rx_err tx_dzero tx_done tx_err link_down bus_fail
  task automatic drive_ev(input logic [9:0] m);
    {rx_early_i, rx_dzero_i, rx_fill_i, rx_pkt_i, rx_err_i,
     tx_dzero_i, tx_done_i, tx_err_i, link_down_i, bus_fail_i} = m;
  endtask

  task automatic pulse(input logic [9:0] m);
    @(negedge clk);
    drive_ev(m);
    @(negedge clk);
    drive_ev('0);
  endtask

  task automatic t_reset();
    rreg(2'd0, rv); chk("R1 status", rv, 16'h0000);
    rreg(2'd1, rv); chk("R1 mask", rv, 16'h0000);
    rreg(2'd2, rv); chk("R1 control", rv, 16'h0000);
    chk("R1 irq", {15'b0, irq_o}, 16'h0000);
  endtask

  task automatic t_latch();
    pulse(10'b11111_111_1_0);
    repeat (3) @(negedge clk);
    rreg(2'd0, rv); chk("R2 all events", rv, 16'h3E2E);
    wreg(2'd0, 16'hFFFF);
    rreg(2'd0, rv); chk("R2 cleared", rv, 16'h0000);
  endtask

  task automatic t_w1c();
    pulse(10'b00010_010_0_0);
    wreg(2'd0, 16'h0008);
    rreg(2'd0, rv); chk("R3 one bit cleared", rv, 16'h0400);
    wreg(2'd0, 16'h0000);
    rreg(2'd0, rv); chk("R3 zero write keeps", rv, 16'h0400);
    rreg(2'd0, rv); chk("R3 read does not clear", rv, 16'h0400);
    wreg(2'd0, 16'h0400);
    rreg(2'd0, rv); chk("R3 last bit cleared", rv, 16'h0000);
  endtask

  task automatic t_cor();
    wreg(2'd2, 16'h0004);
    pulse(10'b00000_001_0_0);
    wreg(2'd0, 16'hFFFF);
    rreg(2'd0, rv); chk("R4 write ignored, read returns", rv, 16'h0002);
    rreg(2'd0, rv); chk("R4 cleared by read", rv, 16'h0000);
    wreg(2'd2, 16'h0000);
  endtask

  task automatic t_collide();
    pulse(10'b00001_000_0_0);
    @(negedge clk);
    drive_ev(10'b00001_000_0_0);
    reg_wr_i = 1; reg_addr_i = 2'd0; reg_wdata_i = 16'h0200;
    @(negedge clk);
    drive_ev('0); reg_wr_i = 0; reg_wdata_i = '0;
    rreg(2'd0, rv); chk("R5 event beats w1c", rv, 16'h0200);
    wreg(2'd0, 16'h0200);
    wreg(2'd2, 16'h0004);
    @(negedge clk);
    drive_ev(10'b00000_100_0_0);
    reg_rd_i = 1; reg_addr_i = 2'd0;
    @(negedge clk);
    drive_ev('0); reg_rd_i = 0;
    rreg(2'd0, rv); chk("R5 event beats read clear", rv, 16'h0020);
    rreg(2'd0, rv); chk("R5 then cleared", rv, 16'h0000);
    wreg(2'd2, 16'h0000);
  endtask

  task automatic t_space();
    @(negedge clk); tx_free_i = 16'd8191;
    @(negedge clk);
    rreg(2'd0, rv); chk("R6 8191 below", rv, 16'h0000);
    @(negedge clk); tx_free_i = 16'd8192;
    @(negedge clk);
    rreg(2'd0, rv); chk("R6 8192 at threshold", rv, 16'h0010);
    wreg(2'd0, 16'h0010);
    rreg(2'd0, rv); chk("R6 not write-clearable", rv, 16'h0010);
    wreg(2'd2, 16'h0004);
    rreg(2'd0, rv);
    rreg(2'd0, rv); chk("R6 not read-clearable", rv, 16'h0010);
    wreg(2'd2, 16'h0000);
    @(negedge clk); tx_free_i = 16'd8193;
    @(negedge clk);
    rreg(2'd0, rv); chk("R6 8193 above", rv, 16'h0010);
    @(negedge clk); tx_free_i = 16'd100;
    @(negedge clk);
    rreg(2'd0, rv); chk("R6 drops", rv, 16'h0000);
  endtask

  task automatic t_misc();
    pulse(10'b00000_000_0_1);
    rreg(2'd0, rv); chk("R7 bus fail unreported", rv, 16'h0000);
    wreg(2'd2, 16'h0008);
    pulse(10'b00000_000_0_1);
    rreg(2'd0, rv); chk("R7 bus fail reported", rv, 16'h0004);
    wreg(2'd0, 16'h0004);
    wreg(2'd2, 16'h0000);
    pulse(10'b00000_000_1_0);
    rreg(2'd0, rv); chk("R7 link down", rv, 16'h0004);
    wreg(2'd0, 16'h0004);
  endtask

  task automatic t_irq();
    wreg(2'd1, 16'h0400);
    wreg(2'd2, 16'h0001);
    pulse(10'b00000_010_0_0);
    @(negedge clk);
    chk("R8 unmasked bit no irq", {15'b0, irq_o}, 16'h0000);
    @(negedge clk);
    drive_ev(10'b00010_000_0_0);
    @(negedge clk);
    drive_ev('0);
    chk("R8 irq registered delay", {15'b0, irq_o}, 16'h0000);
    @(negedge clk);
    chk("R8 irq raised", {15'b0, irq_o}, 16'h0001);
    wreg(2'd2, 16'h0000);
    @(negedge clk);
    chk("R9 enable off", {15'b0, irq_o}, 16'h0000);
    wreg(2'd2, 16'h0002);
    @(negedge clk);
    chk("R9 force without enable", {15'b0, irq_o}, 16'h0000);
    wreg(2'd0, 16'hFFFF);
    wreg(2'd2, 16'h0003);
    @(negedge clk);
    chk("R8 force", {15'b0, irq_o}, 16'h0001);
    wreg(2'd2, 16'h0001);
    @(negedge clk);
    chk("R8 cleared no irq", {15'b0, irq_o}, 16'h0000);
    wreg(2'd1, 16'h0010);
    @(negedge clk); tx_free_i = 16'hFFFF;
    @(negedge clk); @(negedge clk);
    chk("R8 level bit irq", {15'b0, irq_o}, 16'h0001);
    tx_free_i = '0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_latch();
        t_w1c();
        t_cor();
        t_collide();
        t_space();
        t_misc();
        t_irq();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule